// File: doc/BRIEF.md
# Switch-Status Serial Slave

This block is the 16-bit serial slave port of a multi-input switch monitor. A host lowers chip select, clocks a command word in on the data-in pin and reads a status word back on the data-out pin, then raises chip select. The status word reports the interrupt flag, the operating mode and the debounced switch states. It is captured in one snapshot when chip select falls, so nothing that changes during the frame shows up in it. The received command only takes effect when chip select rises, and only if the frame carried exactly 16 clock pulses.

The serial pins are asynchronous to the block. Each one passes through a two-flop synchronizer into the system clock, and all edge detection happens in that domain. An edge on a pin takes effect on the third system clock edge after it. The interrupt request, the mode and the switch vector are already synchronous to the system clock. The interrupt output is active low. It falls on a request and is released when chip select rises.

Top module: `swmon_spi_slave`

## Requirements
- R1: While reset is held and just after it, sdo_oe is 0, irq_n is 1, cmd_word is 0 and cmd_strobe is 0.
- R2: When chip select falls, sdo_oe goes to 1 and sdo shows status bit 15 before any serial clock pulse.
- R3: The status word has this layout. Bit 15 is the interrupt flag, which is the inverse of irq_n. Bits 14:13 are the mode. Bits 3:0 are the switches, where 1 means closed and 0 means open. All other bits are 0.
- R4: The status word is captured when chip select falls. A change of mode, switch or interrupt state later in the frame does not alter the word being shifted out.
- R5: sdo shifts the status word out MSB first. The next bit appears after each falling serial clock edge.
- R6: sdi is sampled on each rising serial clock edge, MSB first. After exactly 16 rising edges, the rise of chip select loads the received word into cmd_word and pulses cmd_strobe for one system clock.
- R7: If a frame has any number of rising serial clock edges other than 16, it is discarded when chip select rises. cmd_word keeps its value and no cmd_strobe is produced.
- R8: While chip select is high, sdo_oe is 0, and serial clock and data activity has no effect on cmd_word or cmd_strobe.
- R9: irq_n goes low on the system clock after irq_req is sampled high. It stays low until chip select rises, and then it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sw_state | input | N_SW | Debounced switch states, 1 = closed |
| irq_req | input | 1 | Interrupt request pulse, system-clock domain |
| mode | input | MODE_W | Current operating mode |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| irq_n | output | 1 | Interrupt output, active low |
| cmd_word | output | 16 | Last committed command word |
| cmd_strobe | output | 1 | One-cycle pulse when cmd_word is committed |

## Verification
The assertions rely on a few conditions about the inputs:
- irq_req, mode and sw_state are synchronous to clk.
- Each serial pin level is held for at least three system clocks, so the synchronizers never miss an edge.
- The serial clock is low whenever chip select changes.

The stimulus holds every serial phase for six system clocks and sets sdi three clocks before each rising serial clock edge. It lowers and raises chip select only while the serial clock is low. The switch, mode and interrupt inputs change only on the falling system clock edge.

// File: rtl/swmon_spi_slave.sv
module swmon_spi_slave #(
  parameter int N_SW   = 4,
  parameter int MODE_W = 2,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [N_SW-1:0]   sw_state,
  input  logic              irq_req,
  input  logic [MODE_W-1:0] mode,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              irq_n,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_strobe
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [2:0] cs_q, sck_q;
  logic [1:0] sdi_q;
  logic       active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh, snap;

  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_rise  = ~cs_q[2] & cs_q[1];
  wire sck_rise = active & sck_q[1] & ~sck_q[2];
  wire sck_fall = active & ~sck_q[1] & sck_q[2];

  always_comb begin
    snap = '0;
    snap[WORD_W-1] = ~irq_n;
    snap[WORD_W-2 -: MODE_W] = mode;
    snap[N_SW-1:0] = sw_state;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active     <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      cmd_word   <= '0;
      cmd_strobe <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      cmd_strobe <= 1'b0;
      if (cs_fall) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        tx_sh   <= snap;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (active && bit_cnt == CNT_FULL) begin
          cmd_word   <= rx_sh;
          cmd_strobe <= 1'b1;
        end
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[WORD_W-2:0], sdi_q[1]};
          if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (cs_rise) irq_n <= 1'b1;
      else if (irq_req) irq_n <= 1'b0;
    end

  assign sdo    = tx_sh[WORD_W-1];
  assign sdo_oe = active;
endmodule

// File: rtl/swmon_spi_slave_chk.sv
module swmon_spi_slave_chk #(parameter int WORD_W = 16) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              irq_n,
  input logic              irq_req,
  input logic [WORD_W-1:0] cmd_word,
  input logic              cmd_strobe,
  input logic              cs_rise
);
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);
  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_strobe |-> $stable(cmd_word));
  a_r8_commit_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> !sdo_oe);
  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !cs_rise) |=> !irq_n);
  a_r9_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> irq_n);
  a_r2_first_bit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> sdo == !$past(irq_n));
endmodule

bind swmon_spi_slave swmon_spi_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n),
  .irq_req(irq_req), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
  .cs_rise(cs_rise)
);

// File: tb/swmon_spi_slave_test.sv
module swmon_spi_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, irq_req = 1'b0;
  logic [3:0] sw_state = '0;
  logic [1:0] mode = '0;
  logic sdo, sdo_oe, irq_n, cmd_strobe;
  logic [15:0] cmd_word;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 0;
  logic [15:0] model_cmd = '0;
  logic model_irq = 1'b0;

  always #4 clk = ~clk;

  swmon_spi_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sw_state(sw_state), .irq_req(irq_req), .mode(mode), .sdo(sdo),
    .sdo_oe(sdo_oe), .irq_n(irq_n), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe)
  );

  always @(posedge clk) if (cmd_strobe) strobes++;

  function automatic logic [15:0] status_of(logic f, logic [1:0] m, logic [3:0] s);
    return {f, m, 9'd0, s};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq_req = 1'b1; wait_clk(1); irq_req = 1'b0;
    check("R9 irq_n low after request", irq_n, 0);
    model_irq = 1'b1;
  endtask

  task automatic run_frame(input logic [15:0] cmd, input int nbits, input bit disturb);
    logic [15:0] exp, got, mask;
    int s0;
    exp = status_of(model_irq, mode, sw_state);
    got = '0; mask = '0; s0 = strobes;
    cs_n = 1'b0; wait_clk(6);
    check("R2 oe on chip select fall", sdo_oe, 1);
    got[15] = sdo; mask[15] = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? cmd[15-i] : 1'($urandom);
      wait_clk(3); sck = 1'b1; wait_clk(6);
      if (disturb && i == 4) begin
        sw_state = ~sw_state; mode = ~mode;
        irq_req = 1'b1; wait_clk(1); irq_req = 1'b0;
      end
      sck = 1'b0; wait_clk(6);
      if (i < 15) begin got[14-i] = sdo; mask[14-i] = 1'b1; end
    end
    check(disturb ? "R4 snapshot held" : "R3 R5 status word", got & mask, exp & mask);
    cs_n = 1'b1; wait_clk(6);
    check("R8 oe off after frame", sdo_oe, 0);
    check("R9 irq released", irq_n, 1);
    model_irq = 1'b0;
    if (nbits == 16) begin
      model_cmd = cmd;
      check("R6 one strobe", strobes - s0, 1);
      check("R6 command committed", cmd_word, model_cmd);
    end else begin
      check("R7 no strobe", strobes - s0, 0);
      check("R7 command kept", cmd_word, model_cmd);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    wait_clk(3);
    check("R1 oe", sdo_oe, 0); check("R1 irq_n", irq_n, 1);
    check("R1 cmd", cmd_word, 0); check("R1 strobe", cmd_strobe, 0);
    rst_n = 1'b1; wait_clk(3);
    check("R1 oe after release", sdo_oe, 0);

    for (int i = 0; i < 20; i++) begin
      sck = ~sck; sdi = ~sdi; wait_clk(5);
    end
    sck = 1'b0; wait_clk(6);
    check("R8 oe while deselected", sdo_oe, 0);
    check("R8 no strobe", strobes, 0);
    check("R8 cmd untouched", cmd_word, 0);

    sw_state = 4'b1010; mode = 2'b01;
    run_frame(16'hA5C3, 16, 0);
    pulse_irq(); sw_state = 4'b0111; mode = 2'b10;
    run_frame(16'h1234, 16, 0);
    run_frame(16'hFFFF, 15, 0);
    run_frame(16'h0F0F, 17, 0);
    run_frame(16'h5555, 0, 0);
    sw_state = 4'b0011; mode = 2'b11;
    run_frame(16'h8001, 16, 1);
    run_frame(16'hBEEF, 16, 0);

    for (int k = 0; k < 20; k++) begin
      int nb;
      sw_state = 4'($urandom); mode = 2'($urandom);
      if ($urandom_range(1, 0) == 1) pulse_irq();
      nb = ($urandom_range(3, 0) == 0) ? int'($urandom_range(18, 1)) : 16;
      run_frame(16'($urandom), nb, $urandom_range(4, 0) == 0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule